// File: doc/BRIEF.md
# Compressed Stream Header and Group Parser

This block sits at the front of a dictionary-style decompressor. It takes the compressed byte stream one byte per transfer and labels each byte with the role it plays. Each label is a mode: header byte, control byte, literal, first byte of a copy item, or second byte of a copy item. When a copy item is complete, the block also gives its decoded length and table index. Hashing, dictionary upkeep and output memory writes belong to later stages, and those stages act on these labels.

The stream opens with an eight-byte header. The header carries a compressed/stored flag and the expected output size. In compressed files the rest of the stream is cut into groups. Each group starts with a sixteen-bit control word, and each bit of that word marks one item as a one-byte literal or a two-byte copy. In stored files every byte after the header is a literal.

The block keeps a five-byte history of the bytes that follow the header, each tagged as data or control. From that history it presents the three most recent data bytes, with control words skipped. This lets a hash stage see the bytes on both sides of a control word as one run. The block counts the output bytes that the items will produce. It raises `done` when the count reaches the header size, and from then on it takes no further bytes.

Back-pressure rules: `in_ready` is high only while `dn_ready` is high and `done` is low. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. `in_valid` may drop at any time. Every transfer gives exactly one `out_valid` pulse in the next cycle. The consumer must take that pulse, because lowering `dn_ready` only holds back later transfers.

Top module: `lzp_stream_parser`

## Requirements
- R1: After reset, `out_valid` and `done` are 0, `ctx_bytes` is 0 and `in_ready` equals `dn_ready`.
- R2: A byte is taken when `in_valid` and `in_ready` are both high. In the next cycle `out_valid` is 1 for exactly one cycle, and `out_byte` holds the taken byte. When no byte was taken, `out_valid` is 0.
- R3: The first 8 bytes taken get mode 0 (header). Bit 0 of header byte 0 is 1 for a compressed file and 0 for a stored file, and its other bits are ignored. Header bytes 1 to 4 hold the output size, least significant byte first.
- R4: In a compressed file, the 2 bytes after the header get mode 1 (control), and so do the 2 bytes that follow every 16 items. The low byte comes first, and bit i of the word describes item i of the group.
- R5: An item whose control bit is 0 is one byte with mode 2 (literal). An item whose control bit is 1 is two bytes, the first with mode 3 and the second with mode 4.
- R6: With each mode-4 output, `copy_len` equals the upper nibble of the copy's first byte plus 3, giving 3 to 18. `copy_idx` equals the lower nibble of the first byte followed by the 8 bits of the second byte.
- R7: In a stored file, every byte after the header gets mode 2.
- R8: Each literal adds 1 to the output count and each copy adds `copy_len`. When the count reaches or passes the size, `done` rises in the cycle after that byte is taken. A size of 0 raises `done` after the last header byte. `done` then stays high and `in_ready` stays low.
- R9: `ctx_bytes` holds the three most recent literal or copy bytes taken after the header, newest in bits [7:0]. Control bytes are skipped, and slots with no such byte yet are 0. It updates together with `out_valid`.
- R10: While `dn_ready` is low, `in_ready` is low, no byte is taken and the parse position does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Compressed stream byte |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Byte is taken this cycle when `in_valid` is high |
| dn_ready | input | 1 | Downstream can accept more results |
| out_valid | output | 1 | One-cycle pulse per taken byte |
| out_mode | output | 3 | 0 header, 1 control, 2 literal, 3 copy first, 4 copy second |
| out_byte | output | 8 | The byte that was labelled |
| copy_len | output | 5 | Decoded copy length, valid with mode 4 |
| copy_idx | output | 12 | Decoded table index, valid with mode 4 |
| ctx_bytes | output | 24 | Three latest data bytes, control bytes skipped |
| done | output | 1 | Output size reached; sticky until reset |

## Verification
The assertions assume a well-formed stream and a consumer that takes every `out_valid` pulse. A well-formed stream means one header, and copy items that are never split by a control word. The block does not police the header or a group's item count, so the checks on header order and copy pairing depend on that input. The stimulus builds each file from its requested size and control-word density, so every stream is legal by construction. It ends a file exactly where the size is reached, and it resets the block between files. Random gaps in `in_valid` and random drops of `dn_ready` exercise the back-pressure without breaking any of these assumptions.

// File: rtl/lzp_pkg.sv
package lzp_pkg;
  typedef enum logic [2:0] {
    M_HDR  = 3'd0,
    M_CTRL = 3'd1,
    M_LIT  = 3'd2,
    M_CPY1 = 3'd3,
    M_CPY2 = 3'd4
  } mode_e;

  // items per group: one control bit each, control word is two bytes
  localparam int CTL_BYTES  = 2;
  localparam int CTL_ITEMS  = 8 * CTL_BYTES;
  // copy item: {len_code, idx_hi} then idx_lo; widths must fill 16 bits
  localparam int LEN_W      = 4;
  localparam int IDX_W      = 12;
  localparam int LEN_BIAS   = 3;
  localparam int LEN_OUT_W  = LEN_W + 1;
  // context window and the history needed to skip a whole control word
  localparam int CTX_BYTES  = 3;
  localparam int HIST_DEPTH = CTX_BYTES + CTL_BYTES;
endpackage

// File: rtl/lzp_seq.sv
module lzp_seq import lzp_pkg::*; #(
  parameter int HDR_BYTES = 8,
  parameter int SIZE_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [7:0]        byte_in,
  output mode_e             mode,
  output logic              last_hdr,
  output logic [SIZE_W-1:0] size
);
  localparam int HC_W       = $clog2(HDR_BYTES);
  localparam int IC_W       = $clog2(CTL_ITEMS + 1);
  localparam int SIZE_BYTES = SIZE_W / 8;

  typedef enum logic [2:0] {S_HDR, S_CTL0, S_CTL1, S_ITEM, S_CPY2, S_RAW} st_e;

  st_e                  st;
  logic [HC_W-1:0]      hcnt;
  logic                 packed_file;
  logic [7:0]           ctl_lo;
  logic [CTL_ITEMS-1:0] ctl_sh;
  logic [IC_W-1:0]      left;

  always_comb begin
    case (st)
      S_HDR:          mode = M_HDR;
      S_CTL0, S_CTL1: mode = M_CTRL;
      S_ITEM:         mode = ctl_sh[0] ? M_CPY1 : M_LIT;
      S_CPY2:         mode = M_CPY2;
      default:        mode = M_LIT;
    endcase
  end

  assign last_hdr = (st == S_HDR) && (hcnt == HC_W'(HDR_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_HDR;
      hcnt        <= '0;
      packed_file <= 1'b0;
      ctl_lo      <= '0;
      ctl_sh      <= '0;
      left        <= '0;
      size        <= '0;
    end else if (take) begin
      case (st)
        S_HDR: begin
          hcnt <= hcnt + 1'b1;
          if (hcnt == '0) packed_file <= byte_in[0];
          for (int k = 0; k < SIZE_BYTES; k++)
            if (hcnt == HC_W'(k + 1)) size[8*k +: 8] <= byte_in;
          if (last_hdr) st <= packed_file ? S_CTL0 : S_RAW;
        end
        S_CTL0: begin
          ctl_lo <= byte_in;
          st     <= S_CTL1;
        end
        S_CTL1: begin
          ctl_sh <= {byte_in, ctl_lo};
          left   <= IC_W'(CTL_ITEMS);
          st     <= S_ITEM;
        end
        S_ITEM: begin
          ctl_sh <= ctl_sh >> 1;
          left   <= left - 1'b1;
          if (ctl_sh[0])                 st <= S_CPY2;
          else if (left == IC_W'(1))     st <= S_CTL0;
        end
        S_CPY2:  st <= (left == '0) ? S_CTL0 : S_ITEM;
        default: st <= S_RAW;
      endcase
    end
  end
endmodule

// File: rtl/lzp_hist.sv
module lzp_hist import lzp_pkg::*; #(
  parameter int DEPTH = HIST_DEPTH,
  parameter int CTX   = CTX_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic [7:0]       din,
  input  logic             is_data,
  output logic [8*CTX-1:0] ctx
);
  logic [DEPTH-1:0][7:0] hb;
  logic [DEPTH-1:0]      tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hb  <= '0;
      tag <= '0;
    end else if (shift) begin
      hb  <= {hb[DEPTH-2:0], din};
      tag <= {tag[DEPTH-2:0], is_data};
    end
  end

  // pick the newest CTX entries tagged as data, skipping control bytes
  always_comb begin
    int n;
    n   = 0;
    ctx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (tag[i] && n < CTX) begin
        ctx[8*n +: 8] = hb[i];
        n = n + 1;
      end
    end
  end
endmodule

// File: rtl/lzp_stream_parser.sv
module lzp_stream_parser import lzp_pkg::*; #(
  parameter int HDR_BYTES = 8,
  parameter int SIZE_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             in_data,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   dn_ready,
  output logic                   out_valid,
  output logic [2:0]             out_mode,
  output logic [7:0]             out_byte,
  output logic [LEN_OUT_W-1:0]   copy_len,
  output logic [IDX_W-1:0]       copy_idx,
  output logic [8*CTX_BYTES-1:0] ctx_bytes,
  output logic                   done
);
  logic              take;
  mode_e             cur_mode;
  logic              last_hdr;
  logic [SIZE_W-1:0] size;
  logic [7:0]        cpy_hi;
  logic [LEN_OUT_W-1:0] cur_len;
  logic [SIZE_W-1:0] out_cnt, add, cnt_nx;

  assign in_ready = dn_ready & ~done;
  assign take     = in_valid & in_ready;

  lzp_seq #(.HDR_BYTES(HDR_BYTES), .SIZE_W(SIZE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .byte_in(in_data),
    .mode(cur_mode), .last_hdr(last_hdr), .size(size)
  );

  lzp_hist u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift(take && cur_mode != M_HDR),
    .din(in_data),
    .is_data(cur_mode != M_CTRL),
    .ctx(ctx_bytes)
  );

  assign cur_len = LEN_OUT_W'(cpy_hi[7 -: LEN_W]) + LEN_OUT_W'(LEN_BIAS);

  always_comb begin
    case (cur_mode)
      M_LIT:   add = SIZE_W'(1);
      M_CPY2:  add = SIZE_W'(cur_len);
      default: add = '0;
    endcase
    cnt_nx = out_cnt + add;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mode  <= '0;
      out_byte  <= '0;
      copy_len  <= '0;
      copy_idx  <= '0;
      cpy_hi    <= '0;
      out_cnt   <= '0;
      done      <= 1'b0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_mode <= cur_mode;
        out_byte <= in_data;
        out_cnt  <= cnt_nx;
        if (cur_mode == M_CPY1) cpy_hi <= in_data;
        if (cur_mode == M_CPY2) begin
          copy_len <= cur_len;
          copy_idx <= {cpy_hi[IDX_W-9:0], in_data};
        end
        if (cur_mode == M_HDR) begin
          if (last_hdr && size == '0) done <= 1'b1;
        end else if ((cur_mode == M_LIT || cur_mode == M_CPY2) && cnt_nx >= size) begin
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lzp_stream_parser_chk.sv
module lzp_stream_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  in_data,
  input logic        in_valid,
  input logic        in_ready,
  input logic        dn_ready,
  input logic        out_valid,
  input logic [2:0]  out_mode,
  input logic [7:0]  out_byte,
  input logic [4:0]  copy_len,
  input logic [11:0] copy_idx,
  input logic [23:0] ctx_bytes,
  input logic        done
);
  logic [2:0] last_mode;
  logic [3:0] hdr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_mode <= 3'd0;
      hdr_seen  <= 4'd0;
    end else if (out_valid) begin
      last_mode <= out_mode;
      if (out_mode == 3'd0 && hdr_seen < 4'd8) hdr_seen <= hdr_seen + 4'd1;
    end
  end

  AST_BLOCKED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n) !dn_ready |-> !in_ready); // R10
  AST_PULSE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid && in_ready)); // R2
  AST_BYTE_ECHO: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> out_byte == $past(in_data)); // R2
  AST_HDR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_mode == 3'd0) |-> hdr_seen < 4'd8); // R3
  AST_HDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_mode != 3'd0) |-> hdr_seen == 4'd8); // R3
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> out_mode <= 3'd4); // R5
  AST_COPY_PAIRED: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_mode == 3'd4) |-> last_mode == 3'd3); // R5
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && out_mode == 3'd4) |-> (copy_len >= 5'd3 && copy_len <= 5'd18)); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R8
  AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) done |-> !in_ready); // R8
endmodule

bind lzp_stream_parser lzp_stream_parser_chk u_chk (.*);

// File: tb/lzp_stream_parser_test.sv
module lzp_stream_parser_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 4096;

  logic clk = 0, rst_n = 0;
  logic [7:0] in_data = 0;
  logic in_valid = 0, dn_ready = 1;
  logic in_ready, out_valid, done;
  logic [2:0] out_mode;
  logic [7:0] out_byte;
  logic [4:0] copy_len;
  logic [11:0] copy_idx;
  logic [23:0] ctx_bytes;

  lzp_stream_parser uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0]  s_byte [MAXB];
  logic [2:0]  s_mode [MAXB];
  logic [4:0]  s_len  [MAXB];
  logic [11:0] s_idx  [MAXB];
  logic        s_done [MAXB];
  int s_n;
  logic [23:0] e_ctx;

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b, logic [2:0] m, logic [4:0] l, logic [11:0] ix, logic d);
    s_byte[s_n] = b; s_mode[s_n] = m; s_len[s_n] = l; s_idx[s_n] = ix; s_done[s_n] = d;
    s_n++;
  endtask

  task automatic gen_header(bit comp, int size);
    logic [7:0] f;
    f = 8'($urandom) & 8'hFE;
    push(comp ? (f | 8'h01) : f, 3'd0, 0, 0, 0);
    for (int k = 0; k < 4; k++) push(8'(size >> (8*k)), 3'd0, 0, 0, 0);
    for (int k = 0; k < 3; k++) push(8'($urandom), 3'd0, 0, 0, (k == 2) && size == 0);
  endtask

  task automatic gen_stored(int size);
    s_n = 0;
    gen_header(0, size);
    for (int i = 1; i <= size; i++) push(8'($urandom), 3'd2, 0, 0, i >= size);
  endtask

  task automatic gen_comp(int size, int cp_pct);
    int prod;
    s_n = 0; prod = 0;
    gen_header(1, size);
    while (prod < size) begin
      int gs;
      logic [15:0] ctl;
      gs = s_n; ctl = 0;
      push(0, 3'd1, 0, 0, 0);
      push(0, 3'd1, 0, 0, 0);
      for (int i = 0; i < 16 && prod < size; i++) begin
        if (int'($urandom % 100) < cp_pct) begin
          logic [3:0] code;
          logic [11:0] ix;
          code = 4'($urandom); ix = 12'($urandom);
          ctl[i] = 1'b1;
          push({code, ix[11:8]}, 3'd3, 0, 0, 0);
          prod += int'(code) + 3;
          push(ix[7:0], 3'd4, 5'(code) + 5'd3, ix, prod >= size);
        end else begin
          prod++;
          push(8'($urandom), 3'd2, 0, 0, prod >= size);
        end
      end
      s_byte[gs] = ctl[7:0];
      s_byte[gs+1] = ctl[15:8];
    end
  endtask

  task automatic do_reset();
    rst_n = 0; in_valid = 0; dn_ready = 1; e_ctx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    chk("R1 out_valid", out_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 ctx", ctx_bytes, 0);
    chk("R1 in_ready", in_ready, 1);
    dn_ready = 0; #1;
    chk("R1 in_ready follows dn_ready", in_ready, 0);
  endtask

  task automatic send_one(int k, bit stored);
    bit took;
    string mt;
    took = 0;
    while (!took) begin
      @(negedge clk);
      dn_ready = ($urandom % 4) != 0;
      in_valid = ($urandom % 5) != 0;
      in_data  = in_valid ? s_byte[k] : 8'h5A;
      #1;
      if (!dn_ready) chk("R10 in_ready low", in_ready, 0);
      took = in_valid && in_ready;
      @(posedge clk); #1;
      if (!took) chk("R10 no output while idle", out_valid, 0);
    end
    in_valid = 0;
    if (s_mode[k] >= 3'd2) e_ctx = {e_ctx[15:0], s_byte[k]};
    mt = (s_mode[k] == 0) ? "R3 mode" : (s_mode[k] == 1) ? "R4 mode" : stored ? "R7 mode" : "R5 mode";
    chk("R2 out_valid", out_valid, 1);
    chk("R2 out_byte", out_byte, s_byte[k]);
    chk(mt, out_mode, s_mode[k]);
    if (s_mode[k] == 3'd4) begin
      chk("R6 copy_len", copy_len, s_len[k]);
      chk("R6 copy_idx", copy_idx, s_idx[k]);
    end
    chk("R8 done", done, s_done[k]);
    chk("R9 ctx", ctx_bytes, e_ctx);
  endtask

  task automatic run_file(bit stored);
    for (int k = 0; k < s_n; k++) send_one(k, stored);
    @(negedge clk);
    dn_ready = 1; in_valid = 1; in_data = 8'hC3;
    #1;
    chk("R8 in_ready closed after done", in_ready, 0);
    @(posedge clk); #1;
    chk("R8 nothing taken after done", out_valid, 0);
    chk("R8 done sticky", done, 1);
    in_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // directed: empty compressed file, done right after header
    do_reset(); gen_comp(0, 0);   run_file(0);
    // stored file, every byte literal
    do_reset(); gen_stored(21);   run_file(1);
    // all literals, multiple full groups and a short tail
    do_reset(); gen_comp(40, 0);  run_file(0);
    // all copies, groups end on copy items
    do_reset(); gen_comp(200, 100); run_file(0);
    // random mixes
    do_reset(); gen_comp(300, 30); run_file(0);
    do_reset(); gen_comp(257, 60); run_file(0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule